// File: doc/BRIEF.md
# DRAM Clock-Enable Arbiter

This block owns the clock-enable outputs of a DDR command interface, one per rank. Several agents may ask for a new clock-enable level:
- a sequencer that puts the DRAMs into self-refresh on a fast reset;
- automatic self-refresh exit once link training completes;
- a second, software-launched self-refresh entry sequencer;
- host channel commands;
- software writes to the clock-enable control bits.

A force-low configuration level sits above all of them. The block merges these requests into one registered level per rank. It mirrors that level into status bits one cycle later.

Channel commands and control-bit writes aimed at the same rank must be spaced apart. The block drops a request that comes too soon after an earlier one. It then records the violation in a sticky error flag, which software clears by writing one. Link training, command encoding and the register bus sit outside the block. They reach it only as single-cycle strobes.

Top module: `cke_ctrl`

## Requirements
- R1: While `rst_ni` is low, `cke_o`, `cke_stat_o`, `spacing_err_o`, `fr_done_o` and `sr_done_o` are all 0.
- R2: If `force_low_i` is 1 at a clock edge, every bit of `cke_o` is 0 after that edge, whatever else is requested. Requests overridden this way are lost: `cke_o` stays 0 after force is released until a new request arrives.
- R3: A pulse on `fr_start_i` while the fast-reset sequencer is idle starts it. The next edge drives all `cke_o` bits to 1. The edge after that drives them to 0 and raises `fr_done_o` for exactly one cycle. A start while the sequencer is busy is ignored.
- R4: A pulse on `train_done_i` drives all `cke_o` bits to 1 at the next edge, unless `dis_exit_i` is 1, in which case it has no effect.
- R5: `sr_start_i` runs the single-entry sequencer with the same timing as R3 and reports through `sr_done_o`.
- R6: A channel command (`chan_we_i[r]`=1) loads `chan_val_i[r]` into `cke_o[r]` at the next edge.
- R7: A control-bit write (`csr_we_i[r]`=1) loads `csr_wdata_i[r]` into `cke_o[r]` at the next edge.
- R8: `cke_stat_o` always equals the value `cke_o` had one cycle earlier.
- R9: When requests coincide, the winner is chosen in this order: fast-reset sequencer, training exit, single-entry sequencer, channel command, control-bit write.
- R10: A channel command to rank r one cycle after an accepted channel command to r is dropped and flags a violation. A gap of two cycles is accepted.
- R11: A channel command one cycle after an accepted write to the same rank is dropped and flags a violation. So is a write one cycle after an accepted channel command to that rank, or a write in the same cycle as a channel command to that rank.
- R12: A violation sets `spacing_err_o` at the next edge. The flag stays set until `err_clr_i` is 1 in a cycle without a new violation. A new violation wins over a simultaneous clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DRAM clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_low_i | input | 1 | Force-low configuration level |
| fr_start_i | input | 1 | Fast-reset self-refresh entry start strobe |
| train_done_i | input | 1 | Link training complete strobe |
| dis_exit_i | input | 1 | Disables automatic self-refresh exit |
| sr_start_i | input | 1 | Software single self-refresh entry start strobe |
| chan_we_i | input | NUM_RANKS | Channel command strobe per rank |
| chan_val_i | input | NUM_RANKS | Channel command clock-enable level per rank |
| csr_we_i | input | NUM_RANKS | Control-bit write strobe per rank |
| csr_wdata_i | input | NUM_RANKS | Control-bit write data |
| err_clr_i | input | 1 | Write-one clear of the spacing error flag |
| cke_o | output | NUM_RANKS | Clock-enable outputs |
| cke_stat_o | output | NUM_RANKS | Clock-enable status bits |
| fr_done_o | output | 1 | Fast-reset sequence done pulse |
| sr_done_o | output | 1 | Single-entry sequence done pulse |
| spacing_err_o | output | 1 | Sticky spacing violation flag |

## Verification
The bench drives several spacing corner cases:
- channel commands one and exactly two cycles apart;
- channel-after-write and write-after-channel;
- a channel command and a write to the same rank in one cycle.

An off-by-one window would either drop the legal two-cycle command or let the one-cycle one through. The bench also collides sequencer steps with training exit and channel commands, where a wrong priority order would show a high level when a low one is expected. Two further cases check force-low. Asserting it during a running sequencer must still give zero. Releasing it must not bring back an overridden request. A clear that arrives together with a new violation must leave the error flag set.

// File: rtl/cke_ctrl_pkg.sv
package cke_ctrl_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CMD  = 2'd1,
    SEQ_LOW  = 2'd2,
    SEQ_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cke_sr_seq.sv
module cke_sr_seq
  import cke_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic req_o,
  output logic val_o,
  output logic done_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start_i) state_d = SEQ_CMD;
      SEQ_CMD:  state_d = SEQ_LOW;
      SEQ_LOW:  state_d = SEQ_DONE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  // high while the entry command issues, low on the following cycle
  assign req_o  = (state_q == SEQ_CMD) || (state_q == SEQ_LOW);
  assign val_o  = (state_q == SEQ_CMD);
  assign done_o = (state_q == SEQ_DONE);

  a_r3_high_then_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && val_o) |=> (req_o && !val_o));
  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_low_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !val_o) |=> done_o);
endmodule

// File: rtl/cke_spacing.sv
module cke_spacing #(
  parameter int unsigned SPACING = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chan_we_i,
  input  logic csr_we_i,
  output logic chan_ok_o,
  output logic csr_ok_o,
  output logic viol_o
);
  localparam int unsigned CW = $clog2(SPACING + 1);
  localparam logic [CW-1:0] LIM = CW'(SPACING - 1);

  logic [CW-1:0] chan_age_q, csr_age_q;
  logic chan_recent, csr_recent;

  assign chan_recent = chan_age_q < LIM;
  assign csr_recent  = csr_age_q < LIM;

  assign chan_ok_o = chan_we_i && !chan_recent && !csr_recent;
  // a same-cycle channel command to this rank always collides with the write
  assign csr_ok_o  = csr_we_i && !chan_recent && !chan_we_i;
  assign viol_o    = (chan_we_i && !chan_ok_o) || (csr_we_i && !csr_ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_age_q <= LIM;
      csr_age_q  <= LIM;
    end else begin
      if (chan_ok_o)        chan_age_q <= '0;
      else if (chan_recent) chan_age_q <= chan_age_q + 1'b1;
      if (csr_ok_o)         csr_age_q  <= '0;
      else if (csr_recent)  csr_age_q  <= csr_age_q + 1'b1;
    end
  end

  a_r10_chan_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_ok_o |=> !chan_ok_o);
  a_r11_csr_after_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_ok_o |=> !csr_ok_o);
  a_r11_chan_after_csr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_ok_o |=> !chan_ok_o);
endmodule

// File: rtl/cke_ctrl.sv
module cke_ctrl
  import cke_ctrl_pkg::*;
#(
  parameter int unsigned NUM_RANKS = 2,
  parameter int unsigned SPACING   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 force_low_i,
  input  logic                 fr_start_i,
  input  logic                 train_done_i,
  input  logic                 dis_exit_i,
  input  logic                 sr_start_i,
  input  logic [NUM_RANKS-1:0] chan_we_i,
  input  logic [NUM_RANKS-1:0] chan_val_i,
  input  logic [NUM_RANKS-1:0] csr_we_i,
  input  logic [NUM_RANKS-1:0] csr_wdata_i,
  input  logic                 err_clr_i,
  output logic [NUM_RANKS-1:0] cke_o,
  output logic [NUM_RANKS-1:0] cke_stat_o,
  output logic                 fr_done_o,
  output logic                 sr_done_o,
  output logic                 spacing_err_o
);
  logic fr_req, fr_val, sr_req, sr_val, exit_req;
  logic [NUM_RANKS-1:0] chan_ok, csr_ok, viol;
  logic [NUM_RANKS-1:0] cke_q, cke_d, stat_q;
  logic err_q, err_d;

  cke_sr_seq u_fr_seq (
    .clk_i, .rst_ni, .start_i(fr_start_i),
    .req_o(fr_req), .val_o(fr_val), .done_o(fr_done_o)
  );

  cke_sr_seq u_sr_seq (
    .clk_i, .rst_ni, .start_i(sr_start_i),
    .req_o(sr_req), .val_o(sr_val), .done_o(sr_done_o)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    cke_spacing #(.SPACING(SPACING)) u_spacing (
      .clk_i, .rst_ni,
      .chan_we_i(chan_we_i[r]), .csr_we_i(csr_we_i[r]),
      .chan_ok_o(chan_ok[r]), .csr_ok_o(csr_ok[r]), .viol_o(viol[r])
    );
  end

  assign exit_req = train_done_i && !dis_exit_i;

  always_comb begin
    cke_d = cke_q;
    if (fr_req)        cke_d = {NUM_RANKS{fr_val}};
    else if (exit_req) cke_d = '1;
    else if (sr_req)   cke_d = {NUM_RANKS{sr_val}};
    else begin
      for (int r = 0; r < NUM_RANKS; r++) begin
        if (chan_ok[r])     cke_d[r] = chan_val_i[r];
        else if (csr_ok[r]) cke_d[r] = csr_wdata_i[r];
      end
    end
    if (force_low_i) cke_d = '0;  // absolute override
  end

  assign err_d = (|viol) || (err_q && !err_clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q  <= '0;
      stat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      cke_q  <= cke_d;
      stat_q <= cke_q;
      err_q  <= err_d;
    end
  end

  assign cke_o         = cke_q;
  assign cke_stat_o    = stat_q;
  assign spacing_err_o = err_q;

  a_r2_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low_i |=> (cke_o == '0));
  a_r4_train_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_done_i && !dis_exit_i && !force_low_i && !fr_req) |=> (cke_o == '1));
  a_r8_stat_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cke_stat_o == $past(cke_o)));
  a_r12_viol_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|viol) |=> spacing_err_o);
  a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spacing_err_o && !err_clr_i) |=> spacing_err_o);
  a_r9_fr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_req && !fr_val && !force_low_i) |=> (cke_o == '0));
endmodule

// File: tb/cke_ctrl_tb.sv
`timescale 1ns/1ps
module cke_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic force_low = 0, fr_start = 0, train_done = 0, dis_exit = 0, sr_start = 0, err_clr = 0;
  logic [1:0] chan_we = 0, chan_val = 0, csr_we = 0, csr_wd = 0;
  logic [1:0] cke, stat;
  logic frd, srd, err;

  always #2.5 clk = ~clk;

  cke_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .force_low_i(force_low), .fr_start_i(fr_start),
    .train_done_i(train_done), .dis_exit_i(dis_exit), .sr_start_i(sr_start),
    .chan_we_i(chan_we), .chan_val_i(chan_val), .csr_we_i(csr_we), .csr_wdata_i(csr_wd),
    .err_clr_i(err_clr), .cke_o(cke), .cke_stat_o(stat), .fr_done_o(frd),
    .sr_done_o(srd), .spacing_err_o(err)
  );

  typedef struct packed {
    logic [1:0] cke;
    logic [1:0] stat;
    logic       err;
    logic       frd;
    logic       srd;
    logic [7:0] req;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int n_chk = 0, n_bad = 0;
  logic [1:0] prev_cke = 2'b00;
  bit finished = 0;

  // monitor: one expected item per edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      n_chk++;
      if ({cke, stat, err, frd, srd} !== {cur.cke, cur.stat, cur.err, cur.frd, cur.srd}) begin
        n_bad++;
        $display("FAIL R%0d: act cke=%b stat=%b err=%b frd=%b srd=%b exp cke=%b stat=%b err=%b frd=%b srd=%b",
                 cur.req, cke, stat, err, frd, srd, cur.cke, cur.stat, cur.err, cur.frd, cur.srd);
      end
    end
  end

  // driver: inputs already set; push the result expected after the coming edge
  task automatic tick(input logic [1:0] c, input logic e, input logic fd, input logic sd,
                      input int r);
    exp_t it;
    it.cke = c; it.stat = prev_cke; it.err = e; it.frd = fd; it.srd = sd; it.req = 8'(r);
    q.push_back(it);
    prev_cke = c;
    @(negedge clk);
    fr_start = 0; train_done = 0; sr_start = 0; chan_we = 0; csr_we = 0; err_clr = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act hung exp finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    n_chk++;  // R1 reset state
    if ({cke, stat, err, frd, srd} !== 7'b0) begin
      n_bad++;
      $display("FAIL R1: act %b exp 0000000", {cke, stat, err, frd, srd});
    end
    rst_ni = 1;
    tick(2'b00, 0, 0, 0, 1);                                  // R1 idle after reset
    chan_we = 2'b01; chan_val = 2'b01; tick(2'b01, 0, 0, 0, 6);   // R6
    chan_we = 2'b01; chan_val = 2'b00; tick(2'b01, 1, 0, 0, 10);  // R10 gap 1 dropped
    tick(2'b01, 1, 0, 0, 12);                                 // R12 sticky
    chan_we = 2'b01; chan_val = 2'b00; tick(2'b00, 1, 0, 0, 6);   // R6
    chan_we = 2'b10; chan_val = 2'b10; tick(2'b10, 1, 0, 0, 6);
    tick(2'b10, 1, 0, 0, 8);                                  // R8
    chan_we = 2'b10; chan_val = 2'b00; tick(2'b00, 1, 0, 0, 10);  // R10 gap 2 accepted
    err_clr = 1; tick(2'b00, 0, 0, 0, 12);                    // R12 clear
    csr_we = 2'b01; csr_wd = 2'b01; tick(2'b01, 0, 0, 0, 7);  // R7
    chan_we = 2'b01; chan_val = 2'b00; tick(2'b01, 1, 0, 0, 11);  // R11 chan after write
    chan_we = 2'b10; chan_val = 2'b10; err_clr = 1; tick(2'b11, 0, 0, 0, 12);
    csr_we = 2'b10; csr_wd = 2'b00; err_clr = 1; tick(2'b11, 1, 0, 0, 12); // R11, R12 set wins
    csr_we = 2'b10; csr_wd = 2'b00; tick(2'b01, 1, 0, 0, 7);  // R7
    err_clr = 1; tick(2'b01, 0, 0, 0, 12);
    chan_we = 2'b01; chan_val = 2'b01; csr_we = 2'b01; csr_wd = 2'b00;
    tick(2'b01, 1, 0, 0, 11);                                 // R11 same cycle: write dropped
    err_clr = 1; tick(2'b01, 0, 0, 0, 12);
    chan_we = 2'b10; chan_val = 2'b10; tick(2'b11, 0, 0, 0, 6);
    force_low = 1; tick(2'b00, 0, 0, 0, 2);                   // R2
    chan_we = 2'b01; chan_val = 2'b01; tick(2'b00, 0, 0, 0, 2);
    train_done = 1; tick(2'b00, 0, 0, 0, 2);
    force_low = 0; tick(2'b00, 0, 0, 0, 2);                   // R2 lost after release
    train_done = 1; tick(2'b11, 0, 0, 0, 4);                  // R4
    csr_we = 2'b11; csr_wd = 2'b00; tick(2'b00, 0, 0, 0, 7);
    dis_exit = 1; train_done = 1; tick(2'b00, 0, 0, 0, 4);    // R4 disabled
    dis_exit = 0;
    fr_start = 1; tick(2'b00, 0, 0, 0, 3);                    // R3
    fr_start = 1; tick(2'b11, 0, 0, 0, 3);                    // R3 busy start ignored
    tick(2'b00, 0, 1, 0, 3);
    tick(2'b00, 0, 0, 0, 3);
    sr_start = 1; tick(2'b00, 0, 0, 0, 5);                    // R5
    tick(2'b11, 0, 0, 0, 5);
    tick(2'b00, 0, 0, 1, 5);
    tick(2'b00, 0, 0, 0, 5);
    csr_we = 2'b11; csr_wd = 2'b11; tick(2'b11, 0, 0, 0, 7);
    csr_we = 2'b11; csr_wd = 2'b00; tick(2'b00, 0, 0, 0, 7);
    sr_start = 1; train_done = 1; tick(2'b11, 0, 0, 0, 9);    // R9 train exit
    chan_we = 2'b11; chan_val = 2'b00; tick(2'b11, 0, 0, 0, 9); // R9 sequencer over channel
    tick(2'b00, 0, 0, 1, 9);
    tick(2'b00, 0, 0, 0, 9);
    fr_start = 1; tick(2'b00, 0, 0, 0, 9);
    tick(2'b11, 0, 0, 0, 9);
    train_done = 1; tick(2'b00, 0, 1, 0, 9);                  // R9 fast-reset over training
    tick(2'b00, 0, 0, 0, 9);
    fr_start = 1; tick(2'b00, 0, 0, 0, 2);
    force_low = 1; tick(2'b00, 0, 0, 0, 2);                   // R2 over sequencer
    force_low = 0; tick(2'b00, 0, 1, 0, 3);
    tick(2'b00, 0, 0, 0, 3);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule